// File: doc/BRIEF.md
# Debug Trace Nibble Buffer

This block sits between a processor core and a 4-bit external debug data port. The core hands it values to publish, such as the computed target address of a change-of-flow instruction or a selected operand. A value arrives as one strobe carrying 32 bits and a size code. The block keeps at most two such values in arrival order. It shifts the oldest one out one nibble per clock on the narrow port, starting with the least significant nibble.

A size code says how many nibbles of the value are meaningful. This covers a byte, a halfword or a full word pushed by a software write-to-port request. Only that many nibbles are sent before the next stored value starts. When both slots still hold data that is waiting to go out, the block raises a stall request so the core holds its next capture back. One exception applies: in the cycle where the oldest value sends its final nibble, a slot frees at that edge. A capture offered in that cycle is taken and no stall is raised.

Top module: `trace_nibble_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, both slots are emptied and the nibble position returns to zero. In the cycle after, `trc_valid` is 0, `trc_nib` is 0 and `core_stall` is 0.
- R2: Whenever no slot is occupied, `trc_valid` is 0 and `trc_nib` is 0.
- R3: Within one stored value, nibble k (bits 4k+3 down to 4k) is presented in the k-th cycle of that value's output, starting at k = 0. The index rises by one each cycle with no gaps.
- R4: Size code 0 emits 2 nibbles, code 1 emits 4 nibbles, and codes 2 and 3 both emit all 8 nibbles.
- R5: Stored values leave in arrival order. Nibble 0 of the next value follows the final nibble of the previous one in the very next cycle.
- R6: `core_stall` is 1 exactly when both slots are occupied and the oldest value is not presenting its final nibble.
- R7: When both slots are full and the oldest value is on its final nibble, `core_stall` is 0. A capture offered in that cycle is stored.
- R8: A capture offered while `core_stall` is 1 is discarded. It never appears on `trc_nib`.
- R9: A capture into an empty buffer appears as nibble 0 with `trc_valid` high in the cycle right after the strobe.
- R10: A reset applied while data is in flight drops all stored data. In the cycle after the reset edge, `trc_valid` and `core_stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one nibble per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Capture strobe from the core |
| cap_data | input | 32 | Value to publish |
| cap_size | input | 2 | Size code: 0 byte, 1 halfword, 2 or 3 word |
| trc_nib | output | 4 | Nibble on the external debug port, zero when idle |
| trc_valid | output | 1 | High when `trc_nib` carries data |
| core_stall | output | 1 | Request to the core to hold further captures |

## Verification
The hardest case to reach from the ports is the single cycle where both slots are full and the oldest value is on its final nibble. A capture there must be taken without a stall. Right next to it, captures offered while stalled must vanish. The bench reaches both by offering a capture every cycle with size codes that rotate, so short and long values meet in every mix. It also uses sparse and bursty strobe patterns, with a reference model of two slots compared every cycle. Each pattern ends with a reset issued while data is still in flight.

// File: rtl/trace_fifo_pkg.sv
package trace_fifo_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } cap_size_e;

  // Number of nibbles a value of the given size code occupies on the port.
  function automatic int unsigned nib_count(logic [1:0] code);
    case (cap_size_e'(code))
      SZ_BYTE: return 2;
      SZ_HALF: return 4;
      default: return 8;
    endcase
  endfunction

  // Slot pointer advance with wrap at the slot count.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned slots);
    return (p + 1 >= slots) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/trace_fifo_store.sv
module trace_fifo_store #(
  parameter int DEPTH  = 2,
  parameter int DATA_W = 32,
  parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        wsize,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rsize,
  output logic [OCC_W-1:0]  occ,
  output logic              full,
  output logic              empty
);
  import trace_fifo_pkg::*;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [1:0]        size_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [OCC_W-1:0]  occ_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) begin
        data_q[wp_q] <= wdata;
        size_q[wp_q] <= wsize;
        wp_q <= PTR_W'(wrap_inc(int'(wp_q), DEPTH));
      end
      if (pop)
        rp_q <= PTR_W'(wrap_inc(int'(rp_q), DEPTH));
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign rdata = data_q[rp_q];
  assign rsize = size_q[rp_q];
  assign occ   = occ_q;
  assign full  = (occ_q == OCC_W'(DEPTH));
  assign empty = (occ_q == '0);
endmodule

// File: rtl/trace_nib_seq.sv
module trace_nib_seq #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4,
  parameter int N_NIB  = DATA_W / NIB_W,
  parameter int IDX_W  = $clog2(N_NIB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              have,
  input  logic [DATA_W-1:0] head_data,
  input  logic [1:0]        head_size,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_valid,
  output logic              last_nib,
  output logic [IDX_W-1:0]  nib_idx
);
  import trace_fifo_pkg::*;

  logic [NIB_W-1:0] nibs [N_NIB];
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] final_idx;

  for (genvar g = 0; g < N_NIB; g++) begin : g_slice
    assign nibs[g] = head_data[g*NIB_W +: NIB_W];
  end

  assign final_idx = IDX_W'(nib_count(head_size) - 1);
  assign last_nib  = have && (idx_q == final_idx);
  assign nib_valid = have;
  assign nib_out   = have ? nibs[idx_q] : '0;
  assign nib_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (rst)           idx_q <= '0;
    else if (last_nib) idx_q <= '0;
    else if (have)     idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/trace_nibble_fifo.sv
module trace_nibble_fifo #(
  parameter int DEPTH  = 2,
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [1:0]        cap_size,
  output logic [NIB_W-1:0]  trc_nib,
  output logic              trc_valid,
  output logic              core_stall
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int N_NIB = DATA_W / NIB_W;
  localparam int IDX_W = $clog2(N_NIB);

  logic [DATA_W-1:0] head_data;
  logic [1:0]        head_size;
  logic [OCC_W-1:0]  occ_w;
  logic              full_w, empty_w;
  logic              last_w, push_w;
  logic [IDX_W-1:0]  nib_idx_w;

  // A slot frees on the final nibble, so stall only when that is not the case.
  assign core_stall = full_w & ~last_w;
  assign push_w     = cap_valid & ~core_stall;

  trace_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .push(push_w), .pop(last_w),
    .wdata(cap_data), .wsize(cap_size),
    .rdata(head_data), .rsize(head_size),
    .occ(occ_w), .full(full_w), .empty(empty_w)
  );

  trace_nib_seq #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_seq (
    .clk(clk), .rst(rst), .have(~empty_w),
    .head_data(head_data), .head_size(head_size),
    .nib_out(trc_nib), .nib_valid(trc_valid),
    .last_nib(last_w), .nib_idx(nib_idx_w)
  );
endmodule

module trace_fifo_chk #(
  parameter int OCC_W = 2,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_valid,
  input logic [3:0]       trc_nib,
  input logic             trc_valid,
  input logic             core_stall,
  input logic             full,
  input logic             last_nib,
  input logic [OCC_W-1:0] occ,
  input logic [IDX_W-1:0] nib_idx
);
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !trc_valid |-> trc_nib == 4'h0);

  assert_index_steps_R3: assert property (@(posedge clk) disable iff (rst)
    (trc_valid && !last_nib) |=> nib_idx == IDX_W'($past(nib_idx) + 1'b1));

  assert_stall_drains_R6: assert property (@(posedge clk) disable iff (rst)
    core_stall |=> trc_valid);

  assert_final_slot_take_R7: assert property (@(posedge clk) disable iff (rst)
    (full && last_nib && cap_valid) |=> full);

  assert_stall_holds_occ_R8: assert property (@(posedge clk) disable iff (rst)
    core_stall |=> occ == $past(occ));

  assert_empty_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (!trc_valid && cap_valid) |=> trc_valid);

  assert_reset_flush_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!trc_valid && !core_stall));
endmodule

bind trace_nibble_fifo trace_fifo_chk u_chk (
  .clk(clk), .rst(rst), .cap_valid(cap_valid),
  .trc_nib(trc_nib), .trc_valid(trc_valid), .core_stall(core_stall),
  .full(full_w), .last_nib(last_w), .occ(occ_w), .nib_idx(nib_idx_w)
);

// File: tb/trace_nibble_fifo_test.sv
module trace_nibble_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cap_valid;
  logic [31:0] cap_data;
  logic [1:0]  cap_size;
  logic [3:0]  trc_nib;
  logic        trc_valid;
  logic        core_stall;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_nibble_fifo uut (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_size(cap_size), .trc_nib(trc_nib), .trc_valid(trc_valid),
    .core_stall(core_stall)
  );

  // Reference model: slot 0 is always the oldest entry.
  logic [31:0] md [2];
  logic [1:0]  ms [2];
  int          mcnt, mptr;
  logic [31:0] rng = 32'h1234_5678;

  // R4: nibbles per size code.
  function automatic int span(logic [1:0] c);
    if (c == 2'd0) return 2;
    if (c == 2'd1) return 4;
    return 8;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    mcnt = 0;
    mptr = 0;
  endtask

  // Compare ports to the model, drive one capture, advance the model.
  task automatic step(bit cv, logic [31:0] d, logic [1:0] s);
    logic       mlast, exp_stall, pop, take;
    logic [3:0] exp_nib;
    mlast     = (mcnt > 0) && (mptr == span(ms[0]) - 1);
    exp_stall = (mcnt == 2) && !mlast;
    exp_nib   = (mcnt > 0) ? 4'((md[0] >> (4 * mptr)) & 32'hF) : 4'h0;
    chk(trc_valid == (mcnt > 0), (mcnt > 0) ? "R9,R5" : "R2",
        32'(trc_valid), 32'(mcnt > 0));
    chk(trc_nib == exp_nib, (mptr > 0) ? "R3,R4" : "R5,R2",
        32'(trc_nib), 32'(exp_nib));
    chk(core_stall == exp_stall, "R6", 32'(core_stall), 32'(exp_stall));
    if (cv && mcnt == 2 && mlast)
      chk(core_stall == 1'b0, "R7", 32'(core_stall), 32'd0);
    if (cv && exp_stall)
      chk(core_stall == 1'b1, "R8", 32'(core_stall), 32'd1);
    cap_valid = cv;
    cap_data  = d;
    cap_size  = s;
    pop  = mlast;
    take = cv && !exp_stall;
    if (pop) begin
      md[0] = md[1];
      ms[0] = ms[1];
      mcnt--;
      mptr = 0;
    end else if (mcnt > 0) begin
      mptr++;
    end
    if (take) begin
      md[mcnt] = d;
      ms[mcnt] = s;
      mcnt++;
    end
  endtask

  initial begin
    rst = 1'b1;
    cap_valid = 1'b0;
    cap_data  = '0;
    cap_size  = '0;
    model_clear();
    repeat (2) @(negedge clk);
    chk(trc_valid == 1'b0, "R1", 32'(trc_valid), 32'd0);
    chk(trc_nib == 4'h0, "R1", 32'(trc_nib), 32'd0);
    chk(core_stall == 1'b0, "R1", 32'(core_stall), 32'd0);
    rst = 1'b0;
    for (int mode = 0; mode < 6; mode++) begin
      for (int cyc = 0; cyc < 400; cyc++) begin
        bit         cv;
        logic [1:0] sz;
        @(negedge clk);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        case (mode)
          0: cv = 1'b1;
          1: cv = rng[0];
          2: cv = (rng[3:0] == 4'h0);
          3: cv = ((cyc / 16) % 2) == 0;
          4: cv = (cyc % 3) != 2;
          default: cv = rng[1] | rng[2];
        endcase
        sz = (mode % 2 == 1) ? rng[9:8] : 2'(cyc / 3);
        step(cv, rng ^ 32'(cyc * 32'h0101_0101), sz);
      end
      // R10: reset with data in flight.
      @(negedge clk);
      cap_valid = 1'b1;
      rst = 1'b1;
      model_clear();
      @(negedge clk);
      chk(trc_valid == 1'b0, "R10", 32'(trc_valid), 32'd0);
      chk(core_stall == 1'b0, "R10", 32'(core_stall), 32'd0);
      chk(trc_nib == 4'h0, "R10", 32'(trc_nib), 32'd0);
      rst = 1'b0;
      cap_valid = 1'b0;
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule